// File: doc/BRIEF.md
# Dual-Bank Triggered Sample Capture Buffer

This block continuously records the samples of one ADC channel into a pair of circular memory banks. A new sample is written on every clock. The write pointer is shared by both banks and steps through the bank depth, wrapping at the end. At any moment one bank is recording and the other bank is either spare or frozen. When a stop pulse arrives and the spare bank is free, the recording bank freezes with its contents intact and recording moves to the other bank on the next clock. No sample slot is skipped.

A frozen bank is offered for readout. The consumer pulls a fixed number of cells from it, one per request. The first cell read lies a programmable number of positions before the address written in the stop cycle. Addresses wrap modulo the bank depth. After the last of those cells has been read, the bank becomes spare again. A stop that arrives while the spare bank is still frozen is dropped, and a sticky overflow flag records the loss. A design that needs several channels places one instance per channel.

Top module: `dual_bank_capture`

## Requirements
- R1: After a clock edge with `rst_n` low, `rd_avail`, `rd_valid`, `rd_last` and `overflow` are all 0.
- R2: Each ADC sample is stored zero-extended. The bits of `rd_data` above the ADC width always read 0.
- R3: Suppose `stop_in` is high at an edge while no bank is frozen. Then the bank written at that edge is frozen, and `rd_avail` is 1 after the edge. The next sample goes to the other bank at the following pointer position.
- R4: The cells read from a frozen bank start at (stop address − `pretrig`) mod DEPTH and step up by one address, wrapping from DEPTH−1 to 0. The stop address is the pointer written in the stop cycle.
- R5: `rd_req` high at an edge while `rd_avail` is 1 yields `rd_valid` = 1 with that cell's value on `rd_data` after the edge. `rd_last` is 1 only for the READ_CNT-th cell of the frozen bank.
- R6: After the READ_CNT-th read, `rd_avail` is 0, unless a stop was accepted at that same edge.
- R7: A stop that arrives while a bank is frozen and its last read is not at that edge is ignored. The frozen contents and read position are unchanged, and `overflow` becomes 1.
- R8: A stop that coincides with the edge of the final read of the frozen bank is accepted. `rd_avail` stays 1 and the newly frozen bank is offered next.
- R9: `rd_req` while `rd_avail` is 0 produces no `rd_valid`.
- R10: Once set, `overflow` stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, one sample per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| adc_data | input | ADC_W | Raw ADC sample |
| stop_in | input | 1 | Stop (trigger) pulse, one cycle |
| pretrig | input | log2(DEPTH) | Number of cells before the stop address at which readout starts |
| rd_req | input | 1 | Request one cell from the frozen bank |
| rd_avail | output | 1 | A frozen bank is waiting for readout |
| rd_valid | output | 1 | `rd_data` holds a requested cell |
| rd_data | output | WORD_W | Stored word read from the frozen bank |
| rd_last | output | 1 | Marks the final cell of the frozen bank |
| overflow | output | 1 | Sticky flag: a stop was lost |

## Verification
The bench builds the block with DEPTH = 64 and READ_CNT = 5. With a 64-entry bank, both banks fill completely within a few hundred cycles, so every cell read back holds a known sample, including cells that lie after the stop point and come from the previous lap. It also makes it cheap to align a stop with pointer position 1, so that a readout window crosses the 63-to-0 wrap. Using five cells instead of the default four makes sure the read counter and the final-cell marker follow the parameter and not a fixed value.

// File: rtl/cap_pkg.sv
// Package: shared types for the dual-bank capture buffer.
// Assumes: nothing beyond a single clock domain.
package cap_pkg;
    // State of the bank that is not currently recording.
    typedef enum logic {
        SPARE_FREE   = 1'b0,
        SPARE_FROZEN = 1'b1
    } spare_state_e;
endpackage

// File: rtl/cap_bank_ram.sv
// Module: two-bank sample memory with one write port and one registered read port.
// Assumes: writes and reads never target the same bank in the same cycle
// (the controller reads only the frozen bank). Contents are not reset.
module cap_bank_ram #(
    parameter int DEPTH  = 256,
    parameter int WORD_W = 16,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_bank,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              rd_en,
    input  logic              rd_bank,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_word
);
    localparam int CELLS = 2 * DEPTH;

    logic [WORD_W-1:0] mem [CELLS];

    // Write the incoming sample on every clock.
    always_ff @(posedge clk) begin
        mem[{wr_bank, wr_addr}] <= wr_word;
    end

    // Register the requested cell of the frozen bank.
    always_ff @(posedge clk) begin
        if (rd_en) begin
            rd_word <= mem[{rd_bank, rd_addr}];
        end
    end
endmodule

// File: rtl/cap_wr_ctrl.sv
// Module: write pointer, recording bank and spare-bank ownership.
// Assumes: release is asserted for exactly the edge of the final read of the
// frozen bank. A stop accepted at that edge re-freezes at once.
module cap_wr_ctrl
    import cap_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stop_in,
    input  logic              release_bank,
    output logic [ADDR_W-1:0] wr_ptr,
    output logic              wr_bank,
    output logic              frozen,
    output logic              freeze,
    output logic              overflow
);
    spare_state_e spare_q;

    assign frozen = (spare_q == SPARE_FROZEN);
    // A stop is accepted when the spare bank is free or is being freed now.
    assign freeze = stop_in && (!frozen || release_bank);

    // Advance the shared write pointer every clock, wrapping at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
        end else if (wr_ptr == ADDR_W'(DEPTH - 1)) begin
            wr_ptr <= '0;
        end else begin
            wr_ptr <= wr_ptr + 1'b1;
        end
    end

    // Swap banks on an accepted stop, free the spare after its last read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_bank <= 1'b0;
            spare_q <= SPARE_FREE;
        end else if (freeze) begin
            wr_bank <= ~wr_bank;
            spare_q <= SPARE_FROZEN;
        end else if (release_bank) begin
            spare_q <= SPARE_FREE;
        end
    end

    // Record lost stops in a sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overflow <= 1'b0;
        end else if (stop_in && !freeze) begin
            overflow <= 1'b1;
        end
    end

    assert_stop_freezes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_in && !frozen) |=> (frozen && (wr_bank != $past(wr_bank))));

    assert_lost_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> $past(stop_in && frozen && !release_bank));

    assert_overflow_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
endmodule

// File: rtl/cap_rd_ctrl.sv
// Module: readout pointer and cell counter for the frozen bank.
// Assumes: freeze is a one-cycle pulse carrying the address written in the
// stop cycle. It takes priority over a read at the same edge.
module cap_rd_ctrl #(
    parameter int DEPTH    = 256,
    parameter int READ_CNT = 4,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(READ_CNT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              freeze,
    input  logic [ADDR_W-1:0] stop_addr,
    input  logic [ADDR_W-1:0] pretrig,
    input  logic              frozen,
    input  logic              rd_req,
    output logic              rd_fire,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              release_bank,
    output logic              rd_valid,
    output logic              rd_last
);
    logic [CNT_W-1:0] cnt_q;

    assign rd_fire      = rd_req && frozen;
    assign release_bank = rd_fire && (cnt_q == CNT_W'(READ_CNT - 1));

    // Load the start cell on freeze, then step through the marked cells.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_addr <= '0;
            cnt_q   <= '0;
        end else if (freeze) begin
            rd_addr <= stop_addr - pretrig;
            cnt_q   <= '0;
        end else if (rd_fire) begin
            rd_addr <= rd_addr + 1'b1;
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    // Flag the cell presented by the memory and mark the final one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_last  <= 1'b0;
        end else begin
            rd_valid <= rd_fire;
            rd_last  <= release_bank;
        end
    end

    assert_no_read_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !frozen) |=> !rd_valid);

    assert_last_is_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_last |-> rd_valid);
endmodule

// File: rtl/dual_bank_capture.sv
// Module: top of the dual-bank triggered capture buffer for one ADC channel.
// Assumes: one sample per clock and a one-cycle stop pulse. pretrig is
// held stable in the stop cycle.
module dual_bank_capture #(
    parameter int ADC_W    = 10,
    parameter int WORD_W   = 16,
    parameter int DEPTH    = 256,
    parameter int READ_CNT = 4,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADC_W-1:0]  adc_data,
    input  logic              stop_in,
    input  logic [ADDR_W-1:0] pretrig,
    input  logic              rd_req,
    output logic              rd_avail,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_last,
    output logic              overflow
);
    logic [ADDR_W-1:0] wr_ptr;
    logic [ADDR_W-1:0] rd_addr;
    logic              wr_bank;
    logic              frozen;
    logic              freeze;
    logic              release_bank;
    logic              rd_fire;
    logic [WORD_W-1:0] wr_word;

    // Zero-extend the raw sample into the stored word.
    assign wr_word  = WORD_W'(adc_data);
    assign rd_avail = frozen;

    cap_wr_ctrl #(.DEPTH(DEPTH)) wr_ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .stop_in      (stop_in),
        .release_bank (release_bank),
        .wr_ptr       (wr_ptr),
        .wr_bank      (wr_bank),
        .frozen       (frozen),
        .freeze       (freeze),
        .overflow     (overflow)
    );

    cap_rd_ctrl #(.DEPTH(DEPTH), .READ_CNT(READ_CNT)) rd_ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .freeze       (freeze),
        .stop_addr    (wr_ptr),
        .pretrig      (pretrig),
        .frozen       (frozen),
        .rd_req       (rd_req),
        .rd_fire      (rd_fire),
        .rd_addr      (rd_addr),
        .release_bank (release_bank),
        .rd_valid     (rd_valid),
        .rd_last      (rd_last)
    );

    cap_bank_ram #(.DEPTH(DEPTH), .WORD_W(WORD_W)) ram_i (
        .clk     (clk),
        .wr_bank (wr_bank),
        .wr_addr (wr_ptr),
        .wr_word (wr_word),
        .rd_en   (rd_fire),
        .rd_bank (~wr_bank),
        .rd_addr (rd_addr),
        .rd_word (rd_data)
    );

    assert_last_frees_bank_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_last && !$past(stop_in)) |-> !rd_avail);

    assert_zero_extend_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_data[WORD_W-1:ADC_W] == '0));
endmodule

// File: tb/dual_bank_capture_tb.sv
module dual_bank_capture_tb_top;
    localparam int ADC_W    = 10;
    localparam int WORD_W   = 16;
    localparam int DEPTH    = 64;
    localparam int READ_CNT = 5;
    localparam int ADDR_W   = $clog2(DEPTH);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADC_W-1:0]  adc_data = '0;
    logic              stop_in = 1'b0;
    logic [ADDR_W-1:0] pretrig = '0;
    logic              rd_req = 1'b0;
    logic              rd_avail, rd_valid, rd_last, overflow;
    logic [WORD_W-1:0] rd_data;

    int checks = 0;
    int errors = 0;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              last;
    } exp_t;
    exp_t exp_q[$];

    // Reference model of the stored banks, following the requirements.
    logic [WORD_W-1:0] mdl_mem [2][DEPTH];
    int mdl_ptr = 0;
    int mdl_bank = 0;
    int mdl_frz_bank = 0;
    int mdl_stop_ptr = 0;
    bit mdl_accept = 0;

    always #2.5 clk = ~clk;

    dual_bank_capture #(.ADC_W(ADC_W), .WORD_W(WORD_W), .DEPTH(DEPTH),
                        .READ_CNT(READ_CNT)) dut_i (
        .clk(clk), .rst_n(rst_n), .adc_data(adc_data), .stop_in(stop_in),
        .pretrig(pretrig), .rd_req(rd_req), .rd_avail(rd_avail),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_last(rd_last),
        .overflow(overflow)
    );

    // Sample stream: a new pseudo-varied value each cycle.
    always @(negedge clk) adc_data <= adc_data + 10'd397;

    always @(posedge clk) begin
        if (!rst_n) begin
            mdl_ptr  = 0;
            mdl_bank = 0;
        end else begin
            mdl_mem[mdl_bank][mdl_ptr] = WORD_W'(adc_data);
            if (stop_in && mdl_accept) begin
                mdl_frz_bank = mdl_bank;
                mdl_stop_ptr = mdl_ptr;
                mdl_bank     = 1 - mdl_bank;
            end
            mdl_ptr = (mdl_ptr + 1) % DEPTH;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Driver: called just after a negedge; pushes the expected cells when accepted.
    task automatic do_stop(input int pt, input bit accept);
        stop_in    = 1'b1;
        pretrig    = ADDR_W'(pt);
        mdl_accept = accept;
        @(posedge clk);
        #1;
        if (accept) begin
            for (int k = 0; k < READ_CNT; k++) begin
                exp_t e;
                e.data = mdl_mem[mdl_frz_bank][(mdl_stop_ptr - pt + k + DEPTH) % DEPTH];
                e.last = (k == READ_CNT - 1);
                exp_q.push_back(e);
            end
        end
        @(negedge clk);
        stop_in    = 1'b0;
        mdl_accept = 0;
    endtask

    task automatic do_read(input int n);
        for (int i = 0; i < n; i++) begin
            rd_req = 1'b1;
            @(negedge clk);
        end
        rd_req = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Monitor: compare every produced cell against the scoreboard (R4, R5, R2).
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                check(0, "R9", "unexpected rd_valid", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(rd_data === e.data, "R4", "cell data", rd_data, e.data);
                check(rd_last === e.last, "R5", "last marker", rd_last, e.last);
                check(rd_data[WORD_W-1:ADC_W] === '0, "R2", "upper bits",
                      rd_data[WORD_W-1:ADC_W], 0);
            end
        end
    end

    initial begin
        #400000;
        check(0, "WATCHDOG", "timeout", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle(4);
        // R1: reset state
        check(rd_avail === 0, "R1", "rd_avail", rd_avail, 0);
        check(rd_valid === 0, "R1", "rd_valid", rd_valid, 0);
        check(rd_last === 0, "R1", "rd_last", rd_last, 0);
        check(overflow === 0, "R1", "overflow", overflow, 0);
        rst_n = 1'b1;
        idle(2 * DEPTH + 10);

        // R9: read with nothing frozen
        do_read(2);
        check(rd_valid === 0, "R9", "rd_valid idle", rd_valid, 0);

        // R3, R4, R5: basic capture and readout
        do_stop(2, 1);
        check(rd_avail === 1, "R3", "rd_avail after stop", rd_avail, 1);
        idle(3);
        do_read(READ_CNT);
        check(rd_avail === 0, "R6", "rd_avail after last", rd_avail, 0);
        do_read(2);
        check(rd_valid === 0, "R6", "rd_valid after release", rd_valid, 0);
        check(exp_q.size() == 0, "R5", "cells drained", exp_q.size(), 0);

        // R4: window crossing the wrap, with cells after the stop point
        idle(DEPTH + 5);
        while (mdl_ptr != 1) @(negedge clk);
        do_stop(3, 1);
        do_read(READ_CNT);
        check(rd_avail === 0, "R6", "rd_avail after wrap read", rd_avail, 0);

        // R8: stop together with the final read
        idle(DEPTH + 5);
        do_stop(0, 1);
        do_read(READ_CNT - 1);
        idle(DEPTH + 5);
        rd_req = 1'b1;
        do_stop(4, 1);
        rd_req = 1'b0;
        check(rd_avail === 1, "R8", "rd_avail after coincident stop", rd_avail, 1);
        check(overflow === 0, "R8", "no overflow", overflow, 0);
        do_read(READ_CNT);
        check(rd_avail === 0, "R8", "second bank released", rd_avail, 0);

        // R7, R10: stop while frozen is lost; frozen data stays intact
        idle(DEPTH + 5);
        do_stop(10, 1);
        idle(7);
        do_stop(1, 0);
        check(overflow === 1, "R7", "overflow set", overflow, 1);
        check(rd_avail === 1, "R7", "still frozen", rd_avail, 1);
        do_read(READ_CNT);
        idle(20);
        check(overflow === 1, "R10", "overflow sticky", overflow, 1);
        check(exp_q.size() == 0, "R7", "cells drained", exp_q.size(), 0);

        idle(3);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule